// File: doc/BRIEF.md
# Basic Update Timer

An up-counting timer with a prescaler and a wrap limit, reached through a small word-addressed register bus. The clock is divided by the prescaler setting plus one. Each prescaler wrap advances the counter. When the counter has reached the limit, the next advance returns it to zero and raises an update event. The update event sets a flag, can request an interrupt and can pulse a trigger output for a neighbouring block.

Software can force an update by writing the event register. A forced update restarts both counters and loads the pending prescaler and limit values into their working copies. A quiet option keeps this forced update from setting the flag. A single-period mode stops the timer by itself at the end of one period. A debug-halt input freezes counting while the freeze option is enabled.

The bus has a one-cycle write strobe. Read data is combinational from the address and has no side effects.

Top module: `tim_basic`

## Requirements
- R1: After reset every register reads 0, and irq_o and trg_o are 0.
- R2: With the prescaler at P and the limit at A, and counting started from a forced update, the update flag (status bit 0) sets exactly (A+1)*(P+1) cycles after the enable write. This holds whatever the quiet bit is.
- R3: Clearing the enable bit (control bit 0) stops the counter. The count holds its value.
- R4: A write of 1 to event bit 0 (address 4) sets the count and the prescaler counter to zero. It also loads the pending prescaler (address 6) into the working prescaler. A prescaler written while the timer runs has no effect until such an update.
- R5: When quiet (control bit 2) is 1, a forced update leaves the flag unchanged. When quiet is 0, a forced update sets the flag.
- R6: When the preload bit (control bit 3) is 1, a limit written to address 7 takes effect only after the next update. When the bit is 0, the written limit takes effect at once.
- R7: When single-period (control bit 1) is set, the update at the end of a period clears the enable bit. The count then stays 0.
- R8: The trigger mode (address 1, bits 1:0) selects trg_o: 0 gives a one-cycle pulse after a forced update, 1 follows the enable bit, 2 gives a one-cycle pulse after any update.
- R9: Writing 0 to status bit 0 (address 3) clears the flag, and writing 1 leaves it unchanged. An update in the same cycle as a clear leaves the flag set.
- R10: irq_o is 1 exactly when the flag and interrupt-enable bit 0 (address 2) are both 1.
- R11: While dbg_halt_i is 1 and the freeze bit (control bit 4) is 1, the count does not change. When the freeze bit is 0, the halt input has no effect.
- R12: The limit accepts 0xFFFF. With the prescaler at 0, the period is then 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when 1 |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| dbg_halt_i | input | 1 | Debug halt request |
| irq_o | output | 1 | Interrupt request |
| trg_o | output | 1 | Trigger output to other blocks |

## Verification
A wrap that sets the flag can land in the same cycle as a software write of 0 to that flag. The bench runs a short period and times the clearing write so that its clock edge is the edge on which the counter wraps. It then reads the flag back and expects it to be set. Separate cycles show that a clear alone drops the flag and that a write of 1 keeps it. In the same way, a write to the prescaler is placed in the middle of a run. The bench shows that the counting rate changes only after the next forced update.

// File: rtl/tim_pkg.sv
package tim_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0, A_TRIG = 3'd1, A_IEN = 3'd2, A_STAT = 3'd3,
    A_EVG  = 3'd4, A_CNT  = 3'd5, A_PSC = 3'd6, A_ARR  = 3'd7
  } reg_addr_e;

  typedef enum logic [1:0] {
    TRG_UG = 2'd0, TRG_EN = 2'd1, TRG_UPD = 2'd2
  } trg_sel_e;

  typedef struct packed {
    logic dbg_stop;
    logic preload;
    logic quiet;
    logic opm;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tim_presc.sv
module tim_presc #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] psc_i,
  output logic         tick_o
);
  logic [W-1:0] pcnt_q, psc_act_q;

  assign tick_o = run_i & ~clr_i & (pcnt_q == psc_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q    <= '0;
      psc_act_q <= '0;
    end else begin
      if (clr_i)       pcnt_q <= '0;
      else if (run_i)  pcnt_q <= tick_o ? '0 : pcnt_q + W'(1);
      if (load_i)      psc_act_q <= psc_i;
    end
  end

  // shadow only changes on updates, which also return the counter to zero
  a_r2_pcnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcnt_q <= psc_act_q);
endmodule

// File: rtl/tim_cnt.sv
module tim_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ug_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] arr_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  // >= so that a limit lowered below the count still wraps
  assign ovf_o = tick_i & ~ug_i & ~wr_i & (cnt_q >= arr_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ug_i)   cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (ovf_o)  cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  a_r4_ug_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (cnt_q == '0));
endmodule

// File: rtl/tim_regs.sv
module tim_regs
  import tim_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      cnt_i,
  input  logic              ovf_i,
  output ctrl_t             ctrl_o,
  output logic [1:0]        trg_sel_o,
  output logic              uie_o,
  output logic              uif_o,
  output logic              ug_o,
  output logic              cnt_wr_o,
  output logic [W-1:0]      psc_pend_o,
  output logic [W-1:0]      arr_eff_o
);
  ctrl_t        ctrl_q;
  logic [1:0]   trg_q;
  logic         uie_q, uif_q;
  logic [W-1:0] psc_q, arr_q, arr_shd_q;
  logic         wr, upd, stat_clr;

  assign wr       = req_i & we_i;
  assign ug_o     = wr & (addr_i == A_EVG) & wdata_i[0];
  assign cnt_wr_o = wr & (addr_i == A_CNT);
  assign stat_clr = wr & (addr_i == A_STAT) & ~wdata_i[0];
  assign upd      = ug_o | ovf_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      trg_q     <= '0;
      uie_q     <= 1'b0;
      uif_q     <= 1'b0;
      psc_q     <= '0;
      arr_q     <= '0;
      arr_shd_q <= '0;
    end else begin
      if (wr && addr_i == A_CTRL)  ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      else if (ovf_i && ctrl_q.opm) ctrl_q.en <= 1'b0;
      if (wr && addr_i == A_TRIG)  trg_q <= wdata_i[1:0];
      if (wr && addr_i == A_IEN)   uie_q <= wdata_i[0];
      if (wr && addr_i == A_PSC)   psc_q <= wdata_i;
      if (wr && addr_i == A_ARR)   arr_q <= wdata_i;
      if (upd)                     arr_shd_q <= arr_q;
      // setting beats a simultaneous clear
      uif_q <= (uif_q & ~stat_clr) | ovf_i | (ug_o & ~ctrl_q.quiet);
    end
  end

  assign ctrl_o     = ctrl_q;
  assign trg_sel_o  = trg_q;
  assign uie_o      = uie_q;
  assign uif_o      = uif_q;
  assign psc_pend_o = psc_q;
  assign arr_eff_o  = ctrl_q.preload ? arr_shd_q : arr_q;

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = {{(W-CTRL_W){1'b0}}, ctrl_q};
      A_TRIG:  rdata_o = {{(W-2){1'b0}}, trg_q};
      A_IEN:   rdata_o = {{(W-1){1'b0}}, uie_q};
      A_STAT:  rdata_o = {{(W-1){1'b0}}, uif_q};
      A_CNT:   rdata_o = cnt_i;
      A_PSC:   rdata_o = psc_q;
      A_ARR:   rdata_o = arr_q;
      default: rdata_o = '0;
    endcase
  end

  a_r5_quiet_ug: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ug_o && ctrl_q.quiet && !uif_q) |=> !uif_q);
  a_r2_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> uif_q);
  a_r7_opm_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && ctrl_q.opm && !(wr && addr_i == A_CTRL)) |=> !ctrl_q.en);
endmodule

// File: rtl/tim_basic.sv
module tim_basic
  import tim_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic              dbg_halt_i,
  output logic              irq_o,
  output logic              trg_o
);
  ctrl_t        ctrl;
  logic [1:0]   trg_sel;
  logic         uie, uif, ug, cnt_wr, ovf, tick, run, upd;
  logic [W-1:0] cnt, psc_pend, arr_eff;
  logic         ug_q, upd_q;

  assign run = ctrl.en & ~(ctrl.dbg_stop & dbg_halt_i);
  assign upd = ug | ovf;

  tim_regs #(.W(W)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .ovf_i(ovf), .ctrl_o(ctrl), .trg_sel_o(trg_sel),
    .uie_o(uie), .uif_o(uif), .ug_o(ug), .cnt_wr_o(cnt_wr),
    .psc_pend_o(psc_pend), .arr_eff_o(arr_eff)
  );

  tim_presc #(.W(W)) u_presc (
    .clk_i, .rst_ni, .run_i(run), .clr_i(ug), .load_i(upd),
    .psc_i(psc_pend), .tick_o(tick)
  );

  tim_cnt #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .ug_i(ug), .wr_i(cnt_wr),
    .wdata_i, .arr_i(arr_eff), .cnt_o(cnt), .ovf_o(ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ug_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      ug_q  <= ug;
      upd_q <= upd;
    end
  end

  always_comb begin
    case (trg_sel)
      TRG_EN:  trg_o = ctrl.en;
      TRG_UPD: trg_o = upd_q;
      default: trg_o = ug_q;
    endcase
  end

  assign irq_o = uif & uie;

  a_r11_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.dbg_stop && dbg_halt_i && !ug && !cnt_wr) |=> $stable(cnt));
endmodule

// File: tb/sim_tim_basic.sv
module sim_tim_basic;
  localparam logic [2:0] CTRL = 0, TRIG = 1, IEN = 2, STAT = 3, EVG = 4, CNT = 5, PSC = 6, ARR = 7;
  localparam int EN = 1, OPM = 2, QUIET = 4, PRE = 8, DBG = 16;

  logic        clk = 0, rst_n = 0, req = 0, we = 0, dbg = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic        irq, trg;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #10 clk = ~clk;

  tim_basic u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .dbg_halt_i(dbg), .irq_o(irq), .trg_o(trg)
  );

  task automatic chk(input string r, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    req = 1; we = 1; addr = a; wdata = 16'(d);
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    addr = a; #1; d = int'(rdata);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 70000) begin @(negedge clk); n++; end
  endtask

  task automatic setup(input int p, input int a, input int c);
    wr(CTRL, c & ~EN); wr(PSC, p); wr(ARR, a); wr(EVG, 1); wr(STAT, 0);
  endtask

  initial begin
    int v, n;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // R1
    for (int i = 0; i < 8; i++) begin rd(3'(i), v); chk("R1", v, 0); end
    chk("R1", int'(irq), 0); chk("R1", int'(trg), 0);

    // R2 sweep
    wr(IEN, 1);
    for (int p = 0; p < 4; p++)
      for (int j = 0; j < 4; j++) begin
        int a;
        a = (j == 3) ? 5 : j + 1;
        setup(p, a, QUIET); wr(CTRL, QUIET | EN);
        wait_irq(n); chk("R2", n, (a + 1) * (p + 1));
      end
    setup(2, 3, 0); wr(CTRL, EN);
    wait_irq(n); chk("R2", n, 12);

    // R12
    setup(0, 16'hFFFF, QUIET); rd(ARR, v); chk("R12", v, 65535);
    wr(CTRL, QUIET | EN); wait_irq(n); chk("R12", n, 65536);

    // R3
    setup(0, 100, QUIET); wr(CTRL, QUIET | EN);
    repeat (5) @(negedge clk); rd(CNT, v); chk("R3", v, 5);
    wr(CTRL, QUIET); rd(CNT, v); chk("R3", v, 6);
    repeat (4) @(negedge clk); rd(CNT, v); chk("R3", v, 6);

    // R4 / R5
    setup(0, 1000, QUIET); wr(CTRL, QUIET | EN);
    repeat (10) @(negedge clk); rd(CNT, v); chk("R4", v, 10);
    wr(PSC, 3); rd(CNT, v); chk("R4", v, 11);
    repeat (4) @(negedge clk); rd(CNT, v); chk("R4", v, 15);
    wr(EVG, 1); rd(CNT, v); chk("R4", v, 0);
    rd(STAT, v); chk("R5", v, 0);
    repeat (3) @(negedge clk); rd(CNT, v); chk("R4", v, 0);
    @(negedge clk); rd(CNT, v); chk("R4", v, 1);
    wr(CTRL, EN); wr(EVG, 1); rd(STAT, v); chk("R5", v, 1);

    // R6
    setup(0, 2, PRE | QUIET); wr(ARR, 9); wr(CTRL, PRE | QUIET | EN);
    wait_irq(n); chk("R6", n, 3);
    wr(STAT, 0); wait_irq(n); chk("R6", n, 9);
    setup(0, 2, QUIET); wr(ARR, 9); wr(CTRL, QUIET | EN);
    wait_irq(n); chk("R6", n, 10);

    // R7
    setup(1, 2, OPM | QUIET); wr(CTRL, OPM | QUIET | EN);
    wait_irq(n); chk("R7", n, 6);
    rd(CTRL, v); chk("R7", v & 1, 0);
    repeat (5) @(negedge clk); rd(CNT, v); chk("R7", v, 0);
    wr(STAT, 0); repeat (12) @(negedge clk); chk("R7", int'(irq), 0);

    // R8
    wr(TRIG, 1); setup(0, 3, QUIET); chk("R8", int'(trg), 0);
    wr(CTRL, QUIET | EN); chk("R8", int'(trg), 1);
    wr(CTRL, QUIET); chk("R8", int'(trg), 0);
    wr(TRIG, 0); wr(EVG, 1); chk("R8", int'(trg), 1);
    @(negedge clk); chk("R8", int'(trg), 0);
    wr(TRIG, 2); setup(0, 3, QUIET); wr(CTRL, QUIET | EN);
    wait_irq(n); chk("R8", n, 4); chk("R8", int'(trg), 1);
    @(negedge clk); chk("R8", int'(trg), 0);

    // R9 / R10: wraps every 4 cycles, next at k=8
    wr(STAT, 1); rd(STAT, v); chk("R9", v, 1);
    wr(STAT, 0); rd(STAT, v); chk("R9", v, 0);
    wr(STAT, 0); rd(STAT, v); chk("R9", v, 1);
    wr(IEN, 0); chk("R10", int'(irq), 0); rd(STAT, v); chk("R10", v, 1);
    wr(IEN, 1); chk("R10", int'(irq), 1);

    // R11
    setup(0, 1000, DBG | QUIET);
    dbg = 1; wr(CTRL, DBG | QUIET | EN);
    repeat (5) @(negedge clk); rd(CNT, v); chk("R11", v, 0);
    dbg = 0; repeat (3) @(negedge clk); rd(CNT, v); chk("R11", v, 3);
    wr(CTRL, QUIET | EN); rd(CNT, v); chk("R11", v, 4);
    dbg = 1; repeat (3) @(negedge clk); rd(CNT, v); chk("R11", v, 7);
    dbg = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung, expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule